// File: doc/BRIEF.md
# Line code error monitor

This block sits behind the word aligner of a serial receiver and inspects every aligned 10-bit code group as it arrives. Data groups and control groups are both checked. A group counts as a coding violation when it is not a legal 8B/10B symbol, or when it is legal only for the opposite running disparity. Payload bit errors that still produce legal symbols are not detected.

Each violation is reported in three ways. A sticky flag rises and stays high until power-on reset or loss of link lock. A one-cycle pulse marks each violation, so an external counter can accumulate them. An internal saturating 8-bit counter can also be read at a fixed address of a simple combinational read port. The running disparity that the check relies on is tracked inside the block. It restarts negative after reset and after lock is lost.

Top module: `line_code_monitor`

## Requirements
- R1: While `lock` is high, a group presented with `grp_vld` high is legal only if a standard 8B/10B encoder at the current running disparity produces it. That encoder covers all 256 data bytes and the 12 control symbols K28.0 to K28.7, K23.7, K27.7, K29.7 and K30.7. The 6-bit sub-block abcdei sits in `grp_code[9:4]` with a in bit 9, and the 4-bit sub-block fghj sits in `grp_code[3:0]` with f in bit 3. Any other group, including a legal symbol whose primary and alternate 7 forms are swapped, is a violation.
- R2: The running disparity is negative after reset and after any clock edge with `lock` low. After each checked group, legal or not, the new disparity is taken from fghj when fghj has other than two ones (more than two gives positive). Otherwise it is taken from abcdei when abcdei has other than three ones (more than three gives positive). Otherwise it is unchanged.
- R3: `err_sticky` goes high at the clock edge that samples a violation. It then stays high while `lock` stays high.
- R4: A clock edge with `lock` low clears `err_sticky` and the running disparity. Groups presented while `lock` is low are not checked: they produce no pulse and no count.
- R5: `err_pulse` is high for exactly the one cycle after each violating group. Back-to-back violations keep it high on consecutive cycles.
- R6: The internal 8-bit count rises by one for each violation and holds at 255 rather than wrapping. Loss of lock does not change it.
- R7: `rd_data` shows the count while `rd_addr` equals 0x1D and shows zero for every other address. Reading never changes the count.
- R8: Asserting `rst_n` low clears `err_sticky`, `err_pulse`, the count and the running disparity.
- R9: A group presented with `grp_vld` low is ignored: it changes neither the outputs nor the running disparity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous |
| lock | input | 1 | High while the link is in lock |
| grp_vld | input | 1 | Marks a code group on `grp_code` in this cycle |
| grp_code | input | 10 | Received code group, abcdei in [9:4], fghj in [3:0] |
| rd_addr | input | 8 | Read address |
| rd_data | output | 8 | Read data: count at 0x1D, zero elsewhere |
| err_sticky | output | 1 | Sticky coding error level |
| err_pulse | output | 1 | One-cycle pulse per coding error |

## Verification
The check is driven with a clean stream from a disparity-tracking encoder that mixes data and control symbols. With no errors injected, it must stay silent, which shows that every legal symbol is accepted at the right disparity. The same stream with single bit flips separates illegal groups from legal symbols that land at the wrong disparity, because a flip shifts the tracked disparity for later groups. Directed groups cover the cases that a bit flip rarely reaches: a comma symbol at the wrong disparity straight after reset, the swapped alternate 7 form, and all-zero and all-one groups. A long run of violations, a lock drop and a mid-run reset separate saturation, lock clearing and reset clearing.

// File: rtl/lcm_pkg.sv
package lcm_pkg;

   localparam int unsigned SYM_W = 10;

   function automatic int unsigned ones_in(input logic [9:0] v);
      int unsigned n;
      n = 0;
      for (int b = 0; b < 10; b++) begin
         if (v[b]) n++;
      end
      return n;
   endfunction

   // negative-disparity form of the 6-bit sub-block, abcdei with a at bit 5
   function automatic logic [5:0] six_of(input logic [4:0] x);
      logic [5:0] s;
      case (x)
         5'd0:  s = 6'b100111;  5'd1:  s = 6'b011101;
         5'd2:  s = 6'b101101;  5'd3:  s = 6'b110001;
         5'd4:  s = 6'b110101;  5'd5:  s = 6'b101001;
         5'd6:  s = 6'b011001;  5'd7:  s = 6'b111000;
         5'd8:  s = 6'b111001;  5'd9:  s = 6'b100101;
         5'd10: s = 6'b010101;  5'd11: s = 6'b110100;
         5'd12: s = 6'b001101;  5'd13: s = 6'b101100;
         5'd14: s = 6'b011100;  5'd15: s = 6'b010111;
         5'd16: s = 6'b011011;  5'd17: s = 6'b100011;
         5'd18: s = 6'b010011;  5'd19: s = 6'b110010;
         5'd20: s = 6'b001011;  5'd21: s = 6'b101010;
         5'd22: s = 6'b011010;  5'd23: s = 6'b111010;
         5'd24: s = 6'b110011;  5'd25: s = 6'b100110;
         5'd26: s = 6'b010110;  5'd27: s = 6'b110110;
         5'd28: s = 6'b001110;  5'd29: s = 6'b101110;
         5'd30: s = 6'b011110;  default: s = 6'b101011;
      endcase
      return s;
   endfunction

   // negative-disparity form of the 4-bit sub-block, fghj with f at bit 3
   function automatic logic [3:0] four_of(input logic [2:0] y, input logic alt7);
      logic [3:0] f;
      case (y)
         3'd0: f = 4'b1011;  3'd1: f = 4'b1001;
         3'd2: f = 4'b0101;  3'd3: f = 4'b1100;
         3'd4: f = 4'b1101;  3'd5: f = 4'b1010;
         3'd6: f = 4'b0110;  default: f = alt7 ? 4'b0111 : 4'b1110;
      endcase
      return f;
   endfunction

   function automatic logic [9:0] encode(input logic [7:0] d, input logic ctl,
                                         input logic rd_pos);
      logic [4:0] x;
      logic [2:0] y;
      logic [5:0] s;
      logic [3:0] f;
      logic       mid;
      logic       alt;
      logic [9:0] g;
      x = d[4:0];
      y = d[7:5];
      if (ctl && x == 5'd28) begin
         f = four_of(y, y == 3'd7);
         if (y == 3'd0 || y == 3'd3 || y == 3'd4 || y == 3'd7) f = ~f;
         g = {6'b001111, f};
         return rd_pos ? ~g : g;
      end
      s = six_of(x);
      if (rd_pos && (ones_in({4'b0, s}) != 3 || x == 5'd7)) s = ~s;
      mid = (ones_in({4'b0, s}) == 3) ? rd_pos : (ones_in({4'b0, s}) > 3);
      alt = ctl ||
            (!mid && (x == 5'd17 || x == 5'd18 || x == 5'd20)) ||
            ( mid && (x == 5'd11 || x == 5'd13 || x == 5'd14));
      f = four_of(y, alt);
      if (mid && (y == 3'd0 || y == 3'd3 || y == 3'd4 || y == 3'd7)) f = ~f;
      return {s, f};
   endfunction

   // one bit per 10-bit pattern: set when the encoder emits it at this disparity
   function automatic logic [1023:0] legal_map(input logic rd_pos);
      logic [1023:0] m;
      m = '0;
      for (int i = 0; i < 256; i++) m[encode(8'(i), 1'b0, rd_pos)] = 1'b1;
      for (int y = 0; y < 8; y++) m[encode({3'(y), 5'd28}, 1'b1, rd_pos)] = 1'b1;
      m[encode({3'd7, 5'd23}, 1'b1, rd_pos)] = 1'b1;
      m[encode({3'd7, 5'd27}, 1'b1, rd_pos)] = 1'b1;
      m[encode({3'd7, 5'd29}, 1'b1, rd_pos)] = 1'b1;
      m[encode({3'd7, 5'd30}, 1'b1, rd_pos)] = 1'b1;
      return m;
   endfunction

   function automatic logic next_disp(input logic [9:0] g, input logic rd_in);
      int unsigned w4;
      int unsigned w6;
      w4 = ones_in({6'b0, g[3:0]});
      w6 = ones_in({4'b0, g[9:4]});
      if (w4 != 2) return w4 > 2;
      if (w6 != 3) return w6 > 3;
      return rd_in;
   endfunction

endpackage

// File: rtl/lcm_symbol_check.sv
module lcm_symbol_check #(
   parameter int unsigned CODE_W = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              lock,
   input  logic              grp_vld,
   input  logic [CODE_W-1:0] grp_code,
   output logic              viol
);
   localparam logic [1023:0] LEGAL_NEG = lcm_pkg::legal_map(1'b0);
   localparam logic [1023:0] LEGAL_POS = lcm_pkg::legal_map(1'b1);

   if (CODE_W != lcm_pkg::SYM_W) begin : g_bad_code_w
      $error("lcm_symbol_check: CODE_W must be 10");
   end

   logic disp_q;
   logic legal;
   logic checked;

   assign checked = grp_vld && lock;
   assign legal   = disp_q ? LEGAL_POS[grp_code] : LEGAL_NEG[grp_code];
   assign viol    = checked && !legal;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       disp_q <= 1'b0;
      else if (!lock)   disp_q <= 1'b0;
      else if (grp_vld) disp_q <= lcm_pkg::next_disp(grp_code, disp_q);
   end

   // R4: a clock edge with lock low leaves the disparity negative
   p_unlock_disp_neg_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !lock |=> !disp_q);
   // R9: no valid strobe, no disparity change
   p_idle_disp_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (lock && !grp_vld) |=> $stable(disp_q));
endmodule

// File: rtl/lcm_err_flags.sv
module lcm_err_flags (
   input  logic clk,
   input  logic rst_n,
   input  logic lock,
   input  logic viol,
   output logic sticky,
   output logic pulse
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     sticky <= 1'b0;
      else if (!lock) sticky <= 1'b0;
      else if (viol)  sticky <= 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pulse <= 1'b0;
      else        pulse <= viol;
   end

   // R3: every pulse comes with the level set
   p_pulse_has_level_r3: assert property (@(posedge clk) disable iff (!rst_n)
      pulse |-> sticky);
   // R3: the level holds while the link stays in lock
   p_level_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (sticky && lock) |=> sticky);
   // R4: losing lock clears the level
   p_unlock_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !lock |=> !sticky);
endmodule

// File: rtl/lcm_err_count.sv
module lcm_err_count #(
   parameter int unsigned CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bump,
   output logic [CNT_W-1:0] cnt
);
   localparam logic [CNT_W-1:0] CNT_TOP = '1;

   if (CNT_W < 1 || CNT_W > 32) begin : g_bad_cnt_w
      $error("lcm_err_count: CNT_W out of range");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      cnt <= '0;
      else if (bump && cnt != CNT_TOP) cnt <= cnt + 1'b1;
   end

   // R6: once full the count stays full
   p_no_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt == CNT_TOP) |=> (cnt == CNT_TOP));
   // R6: without a violation the count does not move
   p_quiet_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !bump |=> $stable(cnt));
endmodule

// File: rtl/line_code_monitor.sv
module line_code_monitor #(
   parameter int unsigned CODE_W   = 10,
   parameter int unsigned CNT_W    = 8,
   parameter int unsigned ADDR_W   = 8,
   parameter int unsigned DATA_W   = 8,
   parameter int unsigned CNT_ADDR = 'h1D
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              lock,
   input  logic              grp_vld,
   input  logic [CODE_W-1:0] grp_code,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data,
   output logic              err_sticky,
   output logic              err_pulse
);
   localparam logic [ADDR_W-1:0] CNT_SEL = ADDR_W'(CNT_ADDR);
   localparam logic [CNT_W-1:0]  CNT_TOP = '1;

   if (DATA_W < CNT_W) begin : g_bad_data_w
      $error("line_code_monitor: DATA_W must hold the count");
   end
   if (ADDR_W < 32 && CNT_ADDR >= (1 << ADDR_W)) begin : g_bad_addr
      $error("line_code_monitor: CNT_ADDR does not fit ADDR_W");
   end

   logic             viol;
   logic [CNT_W-1:0] cnt;
   logic [DATA_W-1:0] cnt_wide;

   lcm_symbol_check #(.CODE_W(CODE_W)) u_check (
      .clk      (clk),
      .rst_n    (rst_n),
      .lock     (lock),
      .grp_vld  (grp_vld),
      .grp_code (grp_code),
      .viol     (viol)
   );

   lcm_err_flags u_flags (
      .clk    (clk),
      .rst_n  (rst_n),
      .lock   (lock),
      .viol   (viol),
      .sticky (err_sticky),
      .pulse  (err_pulse)
   );

   lcm_err_count #(.CNT_W(CNT_W)) u_count (
      .clk   (clk),
      .rst_n (rst_n),
      .bump  (viol),
      .cnt   (cnt)
   );

   if (DATA_W == CNT_W) begin : g_same_w
      assign cnt_wide = cnt;
   end else begin : g_pad_w
      assign cnt_wide = {{(DATA_W-CNT_W){1'b0}}, cnt};
   end

   assign rd_data = (rd_addr == CNT_SEL) ? cnt_wide : '0;

   // R5 R6: each pulse matches one count step, or the count is already full
   p_pulse_steps_count_r5: assert property (@(posedge clk) disable iff (!rst_n)
      err_pulse |-> (cnt == CNT_W'($past(cnt) + 1'b1)) ||
                    (cnt == CNT_TOP && $past(cnt) == CNT_TOP));
   // R6: no pulse, no count change
   p_no_pulse_no_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !err_pulse |-> (cnt == $past(cnt)));
endmodule

// File: tb/line_code_monitor_bench.sv
module line_code_monitor_bench;
   timeunit 1ns;
   timeprecision 1ps;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       lock = 1'b0;
   logic       grp_vld = 1'b0;
   logic [9:0] grp_code = '0;
   logic [7:0] rd_addr = 8'h1D;
   logic [7:0] rd_data;
   logic       err_sticky;
   logic       err_pulse;

   int unsigned n_chk = 0;
   int unsigned n_fail = 0;
   bit          done = 1'b0;

   bit          ok_tab [0:1][0:1023];
   bit          m_rd;
   bit          m_sticky;
   bit          m_pulse;
   int unsigned m_cnt;
   bit          tx_rd;

   always #10 clk = ~clk;

   line_code_monitor u_line_code_monitor (
      .clk(clk), .rst_n(rst_n), .lock(lock), .grp_vld(grp_vld),
      .grp_code(grp_code), .rd_addr(rd_addr), .rd_data(rd_data),
      .err_sticky(err_sticky), .err_pulse(err_pulse)
   );

   function automatic int unsigned bits_set(input logic [9:0] v);
      int unsigned n = 0;
      for (int b = 0; b < 10; b++) n += v[b];
      return n;
   endfunction

   function automatic logic [5:0] tb_six(input int x);
      logic [5:0] t [0:31] = '{6'b100111, 6'b011101, 6'b101101, 6'b110001,
                               6'b110101, 6'b101001, 6'b011001, 6'b111000,
                               6'b111001, 6'b100101, 6'b010101, 6'b110100,
                               6'b001101, 6'b101100, 6'b011100, 6'b010111,
                               6'b011011, 6'b100011, 6'b010011, 6'b110010,
                               6'b001011, 6'b101010, 6'b011010, 6'b111010,
                               6'b110011, 6'b100110, 6'b010110, 6'b110110,
                               6'b001110, 6'b101110, 6'b011110, 6'b101011};
      return t[x];
   endfunction

   function automatic logic [3:0] tb_four(input int y, input bit a7, input bit pos);
      logic [3:0] t [0:7] = '{4'b1011, 4'b1001, 4'b0101, 4'b1100,
                              4'b1101, 4'b1010, 4'b0110, 4'b1110};
      logic [3:0] f = (y == 7 && a7) ? 4'b0111 : t[y];
      if (pos && (y == 0 || y == 3 || y == 4 || y == 7)) f = ~f;
      return f;
   endfunction

   // standard encoder; ctl selects the control symbol with the same x.y
   function automatic logic [9:0] tb_enc(input int x, input int y, input bit ctl,
                                         input bit pos);
      logic [5:0] s;
      bit         mid;
      bit         a7;
      if (ctl && x == 28) begin
         s = 6'b001111;
         return pos ? ~{s, tb_four(y, 1'b1, 1'b1)} : {s, tb_four(y, 1'b1, 1'b1)};
      end
      s = tb_six(x);
      if (bits_set({4'b0, s}) == 3) begin
         if (x == 7 && pos) s = ~s;
         mid = pos;
      end else begin
         if (pos) s = ~s;
         mid = (bits_set({4'b0, s}) > 3);
      end
      a7 = ctl || (!mid && (x == 17 || x == 18 || x == 20)) ||
                  (mid && (x == 11 || x == 13 || x == 14));
      return {s, tb_four(y, a7, mid)};
   endfunction

   function automatic bit tb_disp(input logic [9:0] g, input bit cur);
      int unsigned lo = bits_set({6'b0, g[3:0]});
      int unsigned hi = bits_set({4'b0, g[9:4]});
      if (lo > 2) return 1'b1;
      if (lo < 2) return 1'b0;
      if (hi > 3) return 1'b1;
      if (hi < 3) return 1'b0;
      return cur;
   endfunction

   task automatic chk(input int unsigned act, input int unsigned exp, input string tag);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic chk_all(input string why);
      chk(err_pulse, m_pulse, {"R5 pulse ", why});
      chk(err_sticky, m_sticky, {"R3 sticky ", why});
      chk(rd_data, (rd_addr == 8'h1D) ? m_cnt : 0, {"R7 R6 read ", why});
   endtask

   task automatic step(input bit v, input bit l, input logic [9:0] c,
                       input logic [7:0] a, input string why);
      bit e;
      grp_vld = v; lock = l; grp_code = c; rd_addr = a;
      e = v && l && !ok_tab[m_rd][c];
      if (!l) begin
         m_sticky = 1'b0;
         m_rd = 1'b0;
      end else if (v) begin
         m_rd = tb_disp(c, m_rd);
      end
      if (e) begin
         m_sticky = 1'b1;
         if (m_cnt < 255) m_cnt++;
      end
      m_pulse = e;
      @(posedge clk);
      @(negedge clk);
      chk_all(why);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; grp_vld = 1'b0; lock = 1'b1; rd_addr = 8'h1D;
      m_rd = 0; m_sticky = 0; m_pulse = 0; m_cnt = 0; tx_rd = 0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      chk_all("R8 reset state");
   endtask

   task automatic send_sym(input int x, input int y, input bit ctl, input string why);
      logic [9:0] g = tb_enc(x, y, ctl, tx_rd);
      tx_rd = tb_disp(g, tx_rd);
      step(1'b1, 1'b1, g, 8'h1D, why);
   endtask

   initial begin
      int unsigned seed_dummy;
      seed_dummy = $urandom(32'h5EED_1D01);
      for (int p = 0; p < 2; p++) begin
         for (int i = 0; i < 1024; i++) ok_tab[p][i] = 1'b0;
         for (int i = 0; i < 256; i++) ok_tab[p][tb_enc(i % 32, i / 32, 1'b0, p[0])] = 1'b1;
         for (int y = 0; y < 8; y++) ok_tab[p][tb_enc(28, y, 1'b1, p[0])] = 1'b1;
         ok_tab[p][tb_enc(23, 7, 1'b1, p[0])] = 1'b1;
         ok_tab[p][tb_enc(27, 7, 1'b1, p[0])] = 1'b1;
         ok_tab[p][tb_enc(29, 7, 1'b1, p[0])] = 1'b1;
         ok_tab[p][tb_enc(30, 7, 1'b1, p[0])] = 1'b1;
      end

      do_reset();
      // R2: disparity starts negative, so the positive comma form is wrong
      step(1'b1, 1'b1, 10'b1100000101, 8'h1D, "R2 positive comma after reset");
      do_reset();
      // R1 R2: clean comma, then the same negative form again at positive disparity
      step(1'b1, 1'b1, 10'b0011111010, 8'h1D, "R1 negative comma accepted");
      step(1'b1, 1'b1, 10'b0011111010, 8'h1D, "R2 repeated comma wrong disparity");
      do_reset();
      // R1: primary 7 where alternate 7 is required, then plain illegal groups
      step(1'b1, 1'b1, 10'b1000111110, 8'h1D, "R1 swapped alternate seven");
      step(1'b1, 1'b1, 10'b0000000000, 8'h1D, "R1 all zero group");
      step(1'b1, 1'b1, 10'b1111111111, 8'h1D, "R1 all one group");
      // R7: other addresses read zero, then the count is intact
      step(1'b0, 1'b1, 10'b0, 8'h1C, "R7 neighbour address");
      step(1'b0, 1'b1, 10'b0, 8'hFF, "R7 top address");
      step(1'b0, 1'b1, 10'b0, 8'h1D, "R7 count kept after reads");
      // R9: an illegal group without the valid strobe is ignored
      step(1'b0, 1'b1, 10'b0000000000, 8'h1D, "R9 strobe low");
      // R4: lock low clears the level; groups while unlocked are not checked
      step(1'b1, 1'b0, 10'b0000000000, 8'h1D, "R4 unlocked group");
      step(1'b1, 1'b1, 10'b0011111010, 8'h1D, "R4 disparity restarted negative");
      tx_rd = 1'b1;
      for (int i = 0; i < 64; i++) send_sym(i % 32, (i / 32) * 7, 1'b0, "R1 clean data sweep");
      for (int y = 0; y < 8; y++) send_sym(28, y, 1'b1, "R1 clean control");
      send_sym(23, 7, 1'b1, "R1 clean control");
      send_sym(30, 7, 1'b1, "R1 clean control");

      // mixed stream with injected faults
      for (int n = 0; n < 4000; n++) begin
         int unsigned r = $urandom % 100;
         bit          ctl = ($urandom % 16) == 0;
         int          x = ctl ? 28 : int'($urandom % 32);
         int          y = int'($urandom % 8);
         logic [9:0]  g;
         logic [7:0]  a = (($urandom % 10) == 0) ? 8'($urandom) : 8'h1D;
         if (ctl && ($urandom % 3) == 0) begin
            int picks [0:3] = '{23, 27, 29, 30};
            x = picks[$urandom % 4];
            y = 7;
         end
         if (r < 2) begin
            tx_rd = 1'b0;
            step(1'b1, 1'b0, 10'($urandom), a, "R4 random unlock");
         end else if (r < 20) begin
            step(1'b0, 1'b1, 10'($urandom), a, "R9 random idle");
         end else begin
            g = tb_enc(x, y, ctl, tx_rd);
            tx_rd = tb_disp(g, tx_rd);
            if (r < 25) g[$urandom % 10] ^= 1'b1;
            step(1'b1, 1'b1, g, a, "R1 R2 random stream");
         end
      end

      // R6: long run of violations reaches and holds 255
      for (int n = 0; n < 300; n++) step(1'b1, 1'b1, 10'b0000000000, 8'h1D, "R6 saturation run");
      chk(rd_data, 255, "R6 count saturated");
      step(1'b0, 1'b0, 10'b0, 8'h1D, "R4 R6 unlock keeps count");
      do_reset();
      chk(rd_data, 0, "R8 count cleared by reset");
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end
endmodule